// File: doc/BRIEF.md
# Adaptive Page Promotion Threshold

This block decides when a page that currently lives in the slow non-volatile tier of a hybrid memory should be promoted to DRAM. Each reference event carries the page's reference count for the current epoch and a flag that tells whether the page sits in NVM. The block compares that count with a live threshold. When the count exceeds the threshold for an NVM page, it raises a one-cycle promote strobe.

The threshold is retuned once per epoch. A sliding window keeps the per-page reference counts of the most recent DRAM hits on previously promoted pages. The window's total is compared with the total latched at the previous epoch boundary. When reuse improves, the threshold drops by one, so more pages migrate. When reuse falls, as it does for streaming workloads that never revisit a page, the threshold rises by one and migration is throttled. The threshold is clamped to a fixed band.

Top module: `amt_ctrl`

## Requirements
- R1: After reset, thresh_o is 4 and promote_o is 0. The previous-epoch reuse total is zero and every window slot holds zero.
- R2: A reference with ref_valid_i=1, ref_in_nvm_i=1 (1 means the page is in NVM) and ref_count_i strictly greater than thresh_o sets promote_o to 1 in the next cycle.
- R3: A reference whose count is less than or equal to thresh_o leaves promote_o at 0 in the next cycle. promote_o is also 0 after any cycle that has no valid reference.
- R4: A reference with ref_in_nvm_i=0 (the page is already in DRAM) never produces promote_o, whatever its count.
- R5: On epoch_i, if the window total is greater than the total latched at the previous epoch, thresh_o is one lower in the next cycle.
- R6: On epoch_i, if the window total is smaller than the previous total, thresh_o is one higher in the next cycle.
- R7: On epoch_i, if the two totals are equal, thresh_o is unchanged.
- R8: thresh_o never drops below 1. A lowering decision at 1 leaves it at 1.
- R9: thresh_o never rises above 15. A raising decision at 15 leaves it at 15.
- R10: The window total is the sum of the hit_count_i values of the last 128 hit_valid_i events only. Older hits drop out. The total used at an epoch excludes a hit presented in the same cycle.
- R11: Every epoch latches the current window total as the new previous total. Before the first epoch that total is zero.
- R12: thresh_o changes only in the cycle after an epoch_i pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| epoch_i | input | 1 | Epoch boundary strobe; retunes the threshold |
| ref_valid_i | input | 1 | Reference event valid |
| ref_in_nvm_i | input | 1 | 1: the referenced page is in NVM |
| ref_count_i | input | CW (4) | Reference count of the page in the current epoch |
| hit_valid_i | input | 1 | DRAM hit on a previously promoted page |
| hit_count_i | input | CW (4) | Reference count of that promoted page |
| promote_o | output | 1 | One-cycle promote strobe |
| thresh_o | output | TW (4) | Current promotion threshold |

## Verification
Random references run on every cycle, so the promote decision is tried against counts below, equal to and above many threshold values, and in both tiers. The equal-count case separates a strict compare from a non-strict one. Hit bursts of rising totals drive the threshold down into its floor, and a long burst of zero counts after those tests shows that old hits leave the window: without eviction, the total would not fall and the threshold would not rise. A full window of maximal counts followed by repeated small zero bursts walks the threshold up into its ceiling and then through equal-total epochs that must leave it unchanged.

// File: rtl/amt_pkg.sv
package amt_pkg;
  localparam int unsigned CNT_W     = 4;
  localparam int unsigned THR_W     = 4;
  localparam int unsigned WIN_DEPTH = 128;
  localparam int unsigned THR_MIN   = 1;
  localparam int unsigned THR_MAX   = 15;
  localparam int unsigned THR_INIT  = 4;

  typedef enum logic [1:0] {
    TREND_FLAT = 2'd0,
    TREND_UP   = 2'd1,
    TREND_DOWN = 2'd2
  } trend_e;
endpackage

// File: rtl/amt_reuse_ring.sv
module amt_reuse_ring #(
  parameter int unsigned DEPTH = amt_pkg::WIN_DEPTH,
  parameter int unsigned CW    = amt_pkg::CNT_W,
  parameter int unsigned SW    = CW + $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_valid_i,
  input  logic [CW-1:0] hit_count_i,
  output logic [SW-1:0] sum_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [CW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q;
  logic [SW-1:0] sum_q;
  logic [CW-1:0] oldest;

  assign oldest = slot_q[wr_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[g] <= '0;
      else if (hit_valid_i && wr_ptr_q == PW'(g))   slot_q[g] <= hit_count_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      sum_q    <= '0;
    end else if (hit_valid_i) begin
      wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      // running total: evict oldest, add newest
      sum_q    <= sum_q - SW'(oldest) + SW'(hit_count_i);
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/amt_thresh_adapt.sv
module amt_thresh_adapt
  import amt_pkg::*;
#(
  parameter int unsigned SW     = 11,
  parameter int unsigned TW     = THR_W,
  parameter int unsigned T_MIN  = THR_MIN,
  parameter int unsigned T_MAX  = THR_MAX,
  parameter int unsigned T_INIT = THR_INIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          epoch_i,
  input  logic [SW-1:0] cur_sum_i,
  output logic [TW-1:0] thresh_o
);
  localparam logic [TW-1:0] MIN_V  = TW'(T_MIN);
  localparam logic [TW-1:0] MAX_V  = TW'(T_MAX);
  localparam logic [TW-1:0] INIT_V = TW'(T_INIT);

  logic [SW-1:0] prev_sum_q;
  logic [TW-1:0] thr_q, thr_d;
  trend_e        trend;

  always_comb begin
    if (cur_sum_i > prev_sum_q)      trend = TREND_UP;
    else if (cur_sum_i < prev_sum_q) trend = TREND_DOWN;
    else                             trend = TREND_FLAT;
  end

  // better reuse -> easier promotion; worse reuse -> throttle
  always_comb begin
    thr_d = thr_q;
    unique case (trend)
      TREND_UP:   if (thr_q > MIN_V) thr_d = thr_q - 1'b1;
      TREND_DOWN: if (thr_q < MAX_V) thr_d = thr_q + 1'b1;
      default:    thr_d = thr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q      <= INIT_V;
      prev_sum_q <= '0;
    end else if (epoch_i) begin
      thr_q      <= thr_d;
      prev_sum_q <= cur_sum_i;
    end
  end

  assign thresh_o = thr_q;
endmodule

// File: rtl/amt_promote_gate.sv
module amt_promote_gate #(
  parameter int unsigned CW = amt_pkg::CNT_W,
  parameter int unsigned TW = amt_pkg::THR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_valid_i,
  input  logic          ref_in_nvm_i,
  input  logic [CW-1:0] ref_count_i,
  input  logic [TW-1:0] thresh_i,
  output logic          promote_o
);
  localparam int unsigned MW = (CW > TW) ? CW : TW;

  logic [MW-1:0] cnt_ext, thr_ext;
  logic          fire;

  assign cnt_ext = MW'(ref_count_i);
  assign thr_ext = MW'(thresh_i);
  assign fire    = ref_valid_i && ref_in_nvm_i && (cnt_ext > thr_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) promote_o <= 1'b0;
    else         promote_o <= fire;
  end
endmodule

// File: rtl/amt_ctrl.sv
module amt_ctrl
  import amt_pkg::*;
#(
  parameter int unsigned CW     = CNT_W,
  parameter int unsigned TW     = THR_W,
  parameter int unsigned DEPTH  = WIN_DEPTH,
  parameter int unsigned T_MIN  = THR_MIN,
  parameter int unsigned T_MAX  = THR_MAX,
  parameter int unsigned T_INIT = THR_INIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          epoch_i,
  input  logic          ref_valid_i,
  input  logic          ref_in_nvm_i,
  input  logic [CW-1:0] ref_count_i,
  input  logic          hit_valid_i,
  input  logic [CW-1:0] hit_count_i,
  output logic          promote_o,
  output logic [TW-1:0] thresh_o
);
  localparam int unsigned SW = CW + $clog2(DEPTH);

  logic [SW-1:0] win_sum;
  logic [TW-1:0] thr;

  amt_reuse_ring #(.DEPTH(DEPTH), .CW(CW), .SW(SW)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_valid_i (hit_valid_i),
    .hit_count_i (hit_count_i),
    .sum_o       (win_sum)
  );

  amt_thresh_adapt #(
    .SW(SW), .TW(TW), .T_MIN(T_MIN), .T_MAX(T_MAX), .T_INIT(T_INIT)
  ) u_adapt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .epoch_i   (epoch_i),
    .cur_sum_i (win_sum),
    .thresh_o  (thr)
  );

  amt_promote_gate #(.CW(CW), .TW(TW)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ref_valid_i  (ref_valid_i),
    .ref_in_nvm_i (ref_in_nvm_i),
    .ref_count_i  (ref_count_i),
    .thresh_i     (thr),
    .promote_o    (promote_o)
  );

  assign thresh_o = thr;
endmodule

// File: rtl/amt_ctrl_chk.sv
module amt_ctrl_chk #(
  parameter int unsigned CW    = 4,
  parameter int unsigned TW    = 4,
  parameter int unsigned T_MIN = 1,
  parameter int unsigned T_MAX = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          epoch_i,
  input logic          ref_valid_i,
  input logic          ref_in_nvm_i,
  input logic [CW-1:0] ref_count_i,
  input logic          promote_o,
  input logic [TW-1:0] thresh_o
);
  // R2
  promote_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && ref_in_nvm_i && (32'(ref_count_i) > 32'(thresh_o))) |=> promote_o);

  // R3
  no_promote_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_valid_i || (32'(ref_count_i) <= 32'(thresh_o))) |=> !promote_o);

  // R4
  no_promote_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && !ref_in_nvm_i) |=> !promote_o);

  // R12
  thresh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_i |=> $stable(thresh_o));

  // R8
  thresh_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(thresh_o) >= T_MIN);

  // R9
  thresh_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(thresh_o) <= T_MAX);
endmodule

bind amt_ctrl amt_ctrl_chk #(.CW(CW), .TW(TW), .T_MIN(T_MIN), .T_MAX(T_MAX)) u_chk (.*);

// File: tb/amt_ctrl_bench.sv
`timescale 1ns/1ps
module amt_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       epoch = 1'b0;
  logic       ref_valid = 1'b0;
  logic       ref_nvm = 1'b0;
  logic [3:0] ref_cnt = '0;
  logic       hit_valid = 1'b0;
  logic [3:0] hit_cnt = '0;
  logic       promote;
  logic [3:0] thresh;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    run_refs = 1'b0;
  bit    cmp_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_thr;
  int m_prev;
  int m_prom;
  int m_last_nvm;
  int m_q[$];

  always #2 clk = ~clk;

  amt_ctrl u_amt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .epoch_i(epoch),
    .ref_valid_i(ref_valid), .ref_in_nvm_i(ref_nvm), .ref_count_i(ref_cnt),
    .hit_valid_i(hit_valid), .hit_count_i(hit_cnt),
    .promote_o(promote), .thresh_o(thresh)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr = 4; m_prev = 0; m_prom = 0; m_last_nvm = 0;
      m_q.delete();
    end else begin
      int cur;
      cur = 0;
      foreach (m_q[i]) cur += m_q[i];
      m_prom = (ref_valid && ref_nvm && int'(ref_cnt) > m_thr) ? 1 : 0;
      m_last_nvm = ref_valid ? int'(ref_nvm) : 1;
      if (epoch) begin
        if (cur > m_prev && m_thr > 1)       m_thr--;
        else if (cur < m_prev && m_thr < 15) m_thr++;
        m_prev = cur;
      end
      if (hit_valid) begin
        m_q.push_back(int'(hit_cnt));
        if (m_q.size() > 128) void'(m_q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_tests++;
      if (int'(promote) != m_prom) begin
        n_fail++;
        if (m_prom == 1)
          $display("FAIL R2 promote_o=%0d expected %0d", promote, m_prom);
        else if (m_last_nvm == 0)
          $display("FAIL R4 promote_o=%0d expected %0d", promote, m_prom);
        else
          $display("FAIL R3 promote_o=%0d expected %0d", promote, m_prom);
      end
      n_tests++;
      if (int'(thresh) != m_thr) begin
        n_fail++;
        $display("FAIL %s thresh_o=%0d expected %0d", cur_req, thresh, m_thr);
      end
    end
  end

  // background reference traffic, all counts, both tiers
  always @(negedge clk) begin
    if (run_refs) begin
      ref_valid <= ($urandom % 4) != 0;
      ref_nvm   <= ($urandom % 3) != 0;
      ref_cnt   <= 4'($urandom % 16);
    end else begin
      ref_valid <= 1'b0;
    end
  end

  task automatic push_hits(input int n, input int val);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit_valid = 1'b1;
      hit_cnt   = 4'(val);
    end
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic pulse_epoch(input string req);
    cur_req = req;
    @(negedge clk);
    epoch = 1'b1;
    @(negedge clk);
    epoch = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    n_tests++;
    if (thresh !== 4'd4 || promote !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 thresh_o=%0d promote_o=%0d expected 4 0", thresh, promote);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on   = 1'b1;
    run_refs = 1'b1;
    repeat (40) @(negedge clk);

    // directed promote corners at threshold 4
    run_refs = 1'b0;
    @(negedge clk);
    cur_req = "R2";
    ref_valid = 1'b1; ref_nvm = 1'b1; ref_cnt = 4'd5;   // R2: above
    @(negedge clk); ref_cnt = 4'd4;                     // R3: equal
    @(negedge clk); ref_nvm = 1'b0; ref_cnt = 4'd15;    // R4: DRAM page
    @(negedge clk); ref_valid = 1'b0; ref_nvm = 1'b1;   // R3: idle
    @(negedge clk);
    run_refs = 1'b1;

    pulse_epoch("R11");             // 0 vs 0: unchanged
    push_hits(10, 2);
    pulse_epoch("R5");              // 20 > 0: down to 3
    pulse_epoch("R7");              // 20 = 20: stays 3
    push_hits(10, 3);
    pulse_epoch("R5");              // 50: 2
    push_hits(10, 3);
    pulse_epoch("R5");              // 80: 1
    push_hits(10, 3);
    pulse_epoch("R8");              // 110: clamped at 1
    push_hits(130, 0);              // all older hits evicted
    pulse_epoch("R10");             // 0 < 110: up to 2
    push_hits(128, 15);
    pulse_epoch("R5");              // 1920: down to 1
    for (int r = 0; r < 18; r++) begin
      push_hits(8, 0);
      pulse_epoch((r < 13) ? "R6" : "R9");
    end
    repeat (20) @(negedge clk);
    cmp_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule